// File: doc/BRIEF.md
# Jump and Compare-Branch Next-PC Unit

This block computes the program counter for the next instruction of an 8-bit controller core. It handles two kinds of control transfer. The first is an absolute jump that stays inside a 2K page: the upper PC bits come from the already-incremented PC, and the lower bits come from the opcode and the second instruction byte. The second is a compare-and-branch-if-not-equal. It advances the PC past its three bytes. It then compares two bytes as unsigned numbers, puts the less-than result into the carry flag, and adds a signed 8-bit displacement when the two bytes differ.

Every other opcode advances the PC by an instruction length that the surrounding core supplies. The core fetches the operands and presents the two compare values. The unit registers its result once per valid request, and the result appears on the outputs one clock later.

Top module: `btu_top`

## Requirements
- R1: While `rst` is high, and on the first clock edge after it falls with no request, `res_valid_o` is 0. During reset `next_pc_o`, `carry_o` and `taken_o` are all 0.
- R2: A request presented with `req_valid_i` high at one rising edge appears on the outputs after that edge, with `res_valid_o` high. `res_valid_o` is low after any edge where `req_valid_i` was low.
- R3: An opcode whose bits 4..0 equal 00001 is the absolute jump. `next_pc_o` = {bits 15..11 of (`pc_i`+2), `opcode_i` bits 7..5, `byte2_i`}, `taken_o` = 1, and `carry_o` = `carry_i`. Example: `pc_i`=0345h, opcode 21h, byte2 23h gives 0123h.
- R4: The page of the absolute jump is taken from `pc_i`+2 modulo 2^16. A jump whose first byte sits at 07FEh therefore lands in page 0800h..0FFFh, and one at FFFEh lands in page 0000h.
- R5: Opcodes B4h through BFh are the compare-and-branch. `carry_o` is 1 exactly when `cmp_dst_i` < `cmp_src_i` as unsigned bytes.
- R6: For a compare-and-branch with unequal operands, `next_pc_o` = (`pc_i` + 3 + sign-extended `rel_i`) mod 2^16 and `taken_o` = 1. Example: 56h against 60h sets carry and branches.
- R7: For a compare-and-branch with equal operands, `next_pc_o` = `pc_i` + 3 mod 2^16, `taken_o` = 0 and `carry_o` = 0.
- R8: Every other opcode gives `next_pc_o` = (`pc_i` + `len_i`) mod 2^16, with `taken_o` = 0 and `carry_o` = `carry_i`.
- R9: When `req_valid_i` is low at an edge, `next_pc_o`, `carry_o` and `taken_o` keep their previous values, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Request strobe |
| pc_i | input | 16 | Address of the first instruction byte |
| opcode_i | input | 8 | Opcode byte |
| byte2_i | input | 8 | Second instruction byte (low target byte of the absolute jump) |
| rel_i | input | 8 | Signed branch displacement |
| cmp_dst_i | input | 8 | First compare operand |
| cmp_src_i | input | 8 | Second compare operand |
| len_i | input | 2 | Instruction length used for non-branch opcodes |
| carry_i | input | 1 | Current carry flag |
| res_valid_o | output | 1 | Result strobe |
| next_pc_o | output | 16 | Next program counter |
| carry_o | output | 1 | New carry flag |
| taken_o | output | 1 | Control transfer taken |

## Verification
All 256 opcodes are presented with different lengths and carry inputs. This separates the three decode classes, and it shows that the carry passes through unchanged wherever the instruction does not define it. The absolute jump is swept over every opcode-bit group and a range of second bytes. It is placed at ordinary addresses, just below a page boundary and at the top of memory, so a page taken from the unincremented PC or a failure to wrap would show up. The compare-and-branch is swept over a 16-by-16 grid of operand pairs, including the diagonal, with positive, negative and extreme displacements. This separates less-than, greater-than and equal, and it catches a displacement that is zero-extended or added before the length.

// File: rtl/btu_pkg.sv
package btu_pkg;
  typedef enum logic [1:0] {
    K_SEQ  = 2'd0,
    K_AJMP = 2'd1,
    K_CJNE = 2'd2
  } kind_e;
endpackage

// File: rtl/btu_decode.sv
module btu_decode
  import btu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [DW-1:0] opcode_i,
  output kind_e         kind_o
);
  // Absolute jump: low five opcode bits are 00001.
  // Compare-and-branch: opcodes B4h..BFh.
  always_comb begin
    if (opcode_i[4:0] == 5'b00001)
      kind_o = K_AJMP;
    else if (opcode_i >= DW'(8'hB4) && opcode_i <= DW'(8'hBF))
      kind_o = K_CJNE;
    else
      kind_o = K_SEQ;
  end
endmodule

// File: rtl/btu_ajmp.sv
module btu_ajmp #(
  parameter int PC_W   = 16,
  parameter int PAGE_W = 11,
  parameter int DW     = 8,
  localparam int HI_W  = PC_W - PAGE_W,
  localparam int SEL_W = PAGE_W - DW
) (
  input  logic [PC_W-1:0]  pc_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [DW-1:0]    byte2_i,
  output logic [PC_W-1:0]  target_o
);
  logic [HI_W-1:0] page;

  // The page comes from the address after the two-byte instruction.
  assign page     = HI_W'((pc_i + PC_W'(2)) >> PAGE_W);
  assign target_o = {page, sel_i, byte2_i};
endmodule

// File: rtl/btu_cjne.sv
module btu_cjne #(
  parameter int PC_W = 16,
  parameter int DW   = 8
) (
  input  logic [PC_W-1:0] pc_i,
  input  logic [DW-1:0]   dst_i,
  input  logic [DW-1:0]   src_i,
  input  logic [DW-1:0]   rel_i,
  output logic [PC_W-1:0] target_o,
  output logic            lt_o,
  output logic            ne_o
);
  logic [PC_W-1:0] fall;
  logic [PC_W-1:0] disp;

  assign fall     = pc_i + PC_W'(3);
  assign disp     = {{(PC_W-DW){rel_i[DW-1]}}, rel_i};
  assign lt_o     = dst_i < src_i;
  assign ne_o     = dst_i != src_i;
  assign target_o = ne_o ? fall + disp : fall;
endmodule

// File: rtl/btu_top.sv
module btu_top
  import btu_pkg::*;
#(
  parameter int PC_W   = 16,
  parameter int PAGE_W = 11,
  parameter int DW     = 8,
  parameter int LEN_W  = 2,
  localparam int SEL_W = PAGE_W - DW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid_i,
  input  logic [PC_W-1:0]  pc_i,
  input  logic [DW-1:0]    opcode_i,
  input  logic [DW-1:0]    byte2_i,
  input  logic [DW-1:0]    rel_i,
  input  logic [DW-1:0]    cmp_dst_i,
  input  logic [DW-1:0]    cmp_src_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             carry_i,
  output logic             res_valid_o,
  output logic [PC_W-1:0]  next_pc_o,
  output logic             carry_o,
  output logic             taken_o
);
  kind_e           kind;
  logic [PC_W-1:0] abs_pc;
  logic [PC_W-1:0] rel_pc;
  logic [PC_W-1:0] seq_pc;
  logic            cmp_lt;
  logic            cmp_ne;
  logic [PC_W-1:0] nxt_pc;
  logic            nxt_c;
  logic            nxt_t;

  btu_decode #(.DW(DW)) u_dec (
    .opcode_i (opcode_i),
    .kind_o   (kind)
  );

  btu_ajmp #(.PC_W(PC_W), .PAGE_W(PAGE_W), .DW(DW)) u_abs (
    .pc_i     (pc_i),
    .sel_i    (opcode_i[DW-1 -: SEL_W]),
    .byte2_i  (byte2_i),
    .target_o (abs_pc)
  );

  btu_cjne #(.PC_W(PC_W), .DW(DW)) u_rel (
    .pc_i     (pc_i),
    .dst_i    (cmp_dst_i),
    .src_i    (cmp_src_i),
    .rel_i    (rel_i),
    .target_o (rel_pc),
    .lt_o     (cmp_lt),
    .ne_o     (cmp_ne)
  );

  assign seq_pc = pc_i + PC_W'(len_i);

  always_comb begin
    unique case (kind)
      K_AJMP: begin nxt_pc = abs_pc; nxt_c = carry_i; nxt_t = 1'b1;   end
      K_CJNE: begin nxt_pc = rel_pc; nxt_c = cmp_lt;  nxt_t = cmp_ne; end
      default: begin nxt_pc = seq_pc; nxt_c = carry_i; nxt_t = 1'b0;  end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid_o <= 1'b0;
      next_pc_o   <= '0;
      carry_o     <= 1'b0;
      taken_o     <= 1'b0;
    end else begin
      res_valid_o <= req_valid_i;
      if (req_valid_i) begin
        next_pc_o <= nxt_pc;
        carry_o   <= nxt_c;
        taken_o   <= nxt_t;
      end
    end
  end

  // R1: reset clears the result
  p_reset_clear_r1: assert property (@(posedge clk)
    $past(rst) |-> !res_valid_o && !taken_o && !carry_o);

  // R2: strobe follows the request by one edge
  p_valid_follow_r2: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> res_valid_o == $past(req_valid_i));

  // R3: the absolute jump is always taken
  p_abs_taken_r3: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && req_valid_i && kind == K_AJMP) |-> taken_o);

  // R4: the jump lands in the page after the instruction
  p_abs_page_r4: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && req_valid_i && kind == K_AJMP) |->
      next_pc_o[PC_W-1:PAGE_W] == $past(PC_W'(pc_i + PC_W'(2)) >> PAGE_W));

  // R5, R6: unsigned less-than sets carry and branches
  p_lt_carry_r5: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && req_valid_i && kind == K_CJNE && cmp_dst_i < cmp_src_i) |->
      carry_o && taken_o);

  // R7: equal operands fall through with carry clear
  p_eq_fall_r7: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && req_valid_i && kind == K_CJNE && cmp_dst_i == cmp_src_i) |->
      !carry_o && !taken_o && next_pc_o == $past(pc_i + PC_W'(3)));

  // R8: other opcodes never transfer control
  p_seq_not_taken_r8: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && req_valid_i && kind == K_SEQ) |-> !taken_o && carry_o == $past(carry_i));

  // R9: an idle edge holds the result
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && !req_valid_i) |-> $stable(next_pc_o) && $stable(carry_o) && $stable(taken_o));
endmodule

// File: tb/test_btu_top.sv
`timescale 1ns/1ps
module test_btu_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid_i = 1'b0;
  logic [15:0] pc_i = '0;
  logic [7:0]  opcode_i = '0;
  logic [7:0]  byte2_i = '0;
  logic [7:0]  rel_i = '0;
  logic [7:0]  cmp_dst_i = '0;
  logic [7:0]  cmp_src_i = '0;
  logic [1:0]  len_i = '0;
  logic        carry_i = 1'b0;
  logic        res_valid_o;
  logic [15:0] next_pc_o;
  logic        carry_o;
  logic        taken_o;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  btu_top i_btu_top (
    .clk(clk), .rst(rst), .req_valid_i(req_valid_i), .pc_i(pc_i),
    .opcode_i(opcode_i), .byte2_i(byte2_i), .rel_i(rel_i),
    .cmp_dst_i(cmp_dst_i), .cmp_src_i(cmp_src_i), .len_i(len_i),
    .carry_i(carry_i), .res_valid_o(res_valid_o), .next_pc_o(next_pc_o),
    .carry_o(carry_o), .taken_o(taken_o)
  );

  // Expected {valid, pc, carry, taken}, from the requirements alone.
  function automatic logic [18:0] model(input logic [15:0] pc, input logic [7:0] op,
      input logic [7:0] b2, input logic [7:0] rel, input logic [7:0] d,
      input logic [7:0] s, input logic [1:0] len, input logic c);
    logic [15:0] p;
    logic cc, t;
    if (op[4:0] == 5'b00001) begin
      p = ((pc + 16'd2) & 16'hF800) | {5'd0, op[7:5], b2};
      cc = c; t = 1'b1;
    end else if (op >= 8'hB4 && op <= 8'hBF) begin
      p = pc + 16'd3;
      if (d != s) p = p + {{8{rel[7]}}, rel};
      cc = (d < s); t = (d != s);
    end else begin
      p = pc + {14'd0, len};
      cc = c; t = 1'b0;
    end
    return {1'b1, p, cc, t};
  endfunction

  task automatic check(input string req, input logic [18:0] exp);
    logic [18:0] act;
    act = {res_valid_o, next_pc_o, carry_o, taken_o};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual v=%b pc=%h c=%b t=%b expected v=%b pc=%h c=%b t=%b",
               req, act[18], act[17:2], act[1], act[0], exp[18], exp[17:2], exp[1], exp[0]);
    end
  endtask

  task automatic run(input string req, input logic [15:0] pc, input logic [7:0] op,
      input logic [7:0] b2, input logic [7:0] rel, input logic [7:0] d,
      input logic [7:0] s, input logic [1:0] len, input logic c);
    @(negedge clk);
    req_valid_i = 1'b1; pc_i = pc; opcode_i = op; byte2_i = b2; rel_i = rel;
    cmp_dst_i = d; cmp_src_i = s; len_i = len; carry_i = c;
    @(negedge clk);
    check(req, model(pc, op, b2, rel, d, s, len, c));
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [18:0] held;
    repeat (3) @(negedge clk);
    check("R1 reset", 19'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 idle after reset", 19'd0);

    // Worked examples
    run("R3 example", 16'h0345, 8'h21, 8'h23, 8'h00, 8'h00, 8'h00, 2'd1, 1'b1);
    run("R6 example", 16'h1000, 8'hBF, 8'h00, 8'h10, 8'h56, 8'h60, 2'd1, 1'b0);
    run("R7 example", 16'h1000, 8'hB4, 8'h00, 8'h10, 8'h34, 8'h34, 2'd1, 1'b1);
    run("R4 top wrap", 16'hFFFE, 8'hE1, 8'h55, 8'h00, 8'h00, 8'h00, 2'd0, 1'b0);
    run("R4 page edge", 16'h07FE, 8'h01, 8'h00, 8'h00, 8'h00, 8'h00, 2'd0, 1'b0);
    run("R6 wrap", 16'hFFFC, 8'hB5, 8'h00, 8'h7F, 8'h01, 8'h02, 2'd0, 1'b0);

    // R8/R3/R5: every opcode
    for (int op = 0; op < 256; op++)
      run("R8 opcode sweep", 16'h1234 + 16'(op * 97), 8'(op), 8'(op ^ 8'h5A),
          8'(op * 3), 8'(op), 8'(op >> 1), 2'(op), op[2]);

    // R3/R4: absolute jump sweep
    for (int a = 0; a < 4; a++)
      for (int hi = 0; hi < 8; hi++)
        for (int b = 0; b < 256; b += 17) begin
          logic [15:0] pcs [4];
          pcs[0] = 16'h0345; pcs[1] = 16'h07FE; pcs[2] = 16'hFFFE; pcs[3] = 16'h27FF;
          run("R4 abs sweep", pcs[a], {3'(hi), 5'b00001}, 8'(b), 8'h00, 8'h00,
              8'h00, 2'd3, b[0]);
        end

    // R5/R6/R7: compare grid
    for (int d = 0; d < 256; d += 17)
      for (int s = 0; s < 256; s += 17) begin
        logic [7:0] rels [4];
        rels[0] = 8'h80; rels[1] = 8'h7F; rels[2] = 8'hFE; rels[3] = 8'h05;
        run("R5 R6 R7 compare grid", 16'h8000 + 16'(d * 5), 8'hB4 + 8'((d + s) % 12),
            8'h00, rels[(d + s) % 4], 8'(d), 8'(s), 2'd1, 1'b1);
      end

    // R9: idle edges hold the result, R2 drops the strobe
    run("R9 setup", 16'h4000, 8'hB8, 8'h00, 8'h20, 8'h10, 8'h20, 2'd1, 1'b0);
    held = model(16'h4000, 8'hB8, 8'h00, 8'h20, 8'h10, 8'h20, 2'd1, 1'b0);
    @(negedge clk);
    req_valid_i = 1'b0; pc_i = 16'hAAAA; opcode_i = 8'h21; carry_i = 1'b1;
    cmp_dst_i = 8'h00; cmp_src_i = 8'h00;
    @(negedge clk);
    check("R9 R2 idle hold", {1'b0, held[17:0]});
    @(negedge clk);
    check("R9 idle hold again", {1'b0, held[17:0]});

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule